// File: doc/BRIEF.md
# Host Pipe Reset and Enable Lifecycle Controller

This block holds the per-pipe run state of a bank of host pipes. For each pipe it has an enable bit, a firmware-held reset bit, a data-toggle bit (DATA0/DATA1), a bank byte counter, a small pipe state machine, a sticky access-error flag and a configuration word. It decides what a pipe reset clears and what it keeps, and it gates FIFO accesses so that a pipe that is disabled or held in reset takes no data.

Firmware uses one register write port. Each write names a pipe and sets that pipe's enable and reset bits. It can also pulse a toggle-clear and load the configuration word. A pipe reset clears the runtime state at once and keeps it cleared until firmware writes the reset bit back to 0. The configuration, the enable bit and the data toggle survive the reset. A bus-reset-complete input disables every pipe and drops its allocation. Transaction-complete pulses flip the toggle and release the bank.

Top module: `hpipe_lifecycle`

## Requirements
- R1: After the synchronous active-low reset, every pipe has enable, reset bit, toggle, busy, access-error, byte count and configuration all at 0.
- R2: A write with `wr_valid_i`=1 loads `wr_enable_i` and `wr_reset_i` into the enable and reset bits of pipe `wr_pipe_i`. The new values show at the outputs one cycle later.
- R3: A write with `wr_reset_i`=1 clears that pipe's byte count, busy state and access-error flag on the next cycle. The count and busy state stay at 0 while the reset bit is 1. The enable bit and the configuration word are kept.
- R4: A FIFO request to a pipe that is disabled or has its reset bit at 1 gets `fifo_ack_o`=0 in the same cycle. It leaves the byte count unchanged and sets that pipe's access-error flag on the next cycle. The flag is sticky and only a reset-setting write clears it. A clear in the same cycle as a rejected request wins.
- R5: A `xfer_done_i[p]` pulse on a pipe that is enabled and not in reset, and that is not disabled or reset in the same cycle, flips its toggle on the next cycle. It also releases the bank: the count goes to 0 and busy to 0. If an accepted FIFO access comes in the same cycle, the count becomes 1 and busy becomes 1 instead.
- R6: A write with `wr_tgl_clr_i`=1 sets that pipe's toggle to 0 (DATA0) on the next cycle. This wins over a transaction-complete pulse in the same cycle.
- R7: While a pipe's enable bit is 0, its toggle, byte count and busy state are 0.
- R8: `bus_rst_done_i`=1 clears the enable bit of every pipe and bit 0 (allocated) of every configuration word on the next cycle. It wins over a write in the same cycle. The other configuration bits are kept.
- R9: A FIFO request to an enabled pipe that is not in reset is acknowledged combinationally in the same cycle. On the next cycle the pipe is busy and its byte count has gone up by 1, saturating at 2^CNT_W-1.
- R10: A write with `wr_cfg_we_i`=1 loads `wr_cfg_i` into that pipe's configuration on the next cycle, whatever the state of its reset bit.
- R11: Setting and later clearing a pipe's reset bit leaves its toggle unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid_i | input | 1 | Register write strobe |
| wr_pipe_i | input | PIPE_W | Pipe addressed by the write |
| wr_enable_i | input | 1 | New enable bit value |
| wr_reset_i | input | 1 | New pipe reset bit value |
| wr_tgl_clr_i | input | 1 | Clear the data toggle to DATA0 |
| wr_cfg_we_i | input | 1 | Load the configuration word |
| wr_cfg_i | input | CFG_W | Configuration word, bit 0 = allocated |
| bus_rst_done_i | input | 1 | Bus reset sent: disable and deallocate all pipes |
| xfer_done_i | input | NUM_PIPES | Per-pipe successful transaction pulse |
| fifo_req_i | input | 1 | FIFO byte access request |
| fifo_pipe_i | input | PIPE_W | Pipe addressed by the FIFO access |
| fifo_ack_o | output | 1 | FIFO access accepted (combinational) |
| pipe_en_o | output | NUM_PIPES | Enable bits |
| pipe_rst_o | output | NUM_PIPES | Reset bits |
| pipe_tgl_o | output | NUM_PIPES | Data toggle (0 = DATA0) |
| pipe_busy_o | output | NUM_PIPES | Bank holds data |
| pipe_err_o | output | NUM_PIPES | Sticky access-error flags |
| pipe_cnt_o | output | NUM_PIPES*CNT_W | Bank byte counts, pipe 0 in the low bits |
| pipe_cfg_o | output | NUM_PIPES*CFG_W | Configuration words, pipe 0 in the low bits |

## Verification
If a reset clears too much, the lost toggle or configuration shows on `pipe_tgl_o` or `pipe_cfg_o` in the cycle after the reset-setting write. If it clears too little, a stale count or busy bit remains visible in that same cycle. A gating fault shows in the same cycle as `fifo_ack_o` being wrong. The count, the busy bit and the error flag then go wrong one cycle later. A toggle that flips while the pipe is inactive, or loses against a transaction pulse, is wrong at the port one cycle after the pulse. It stays wrong until the next clear, so later transactions use the wrong DATA PID.

// File: rtl/hpipe_pkg.sv
// Package: shared types for the host pipe lifecycle controller.
// Assumes: nothing beyond IEEE 1800-2017.
package hpipe_pkg;
    // Pipe run state: held cleared, ready with empty bank, bank filling.
    typedef enum logic [1:0] {
        PS_HOLD  = 2'd0,
        PS_READY = 2'd1,
        PS_FILL  = 2'd2
    } pipe_state_e;
endpackage

// File: rtl/hpipe_fifo_gate.sv
// Module: hpipe_fifo_gate
// Decodes a FIFO access onto one pipe. It accepts the access when that pipe
// is active (enabled, reset bit 0) and otherwise marks it as rejected.
// Assumes: fifo_pipe_i < NUM_PIPES.
module hpipe_fifo_gate #(
    parameter int NUM_PIPES = 4,
    localparam int PIPE_W = $clog2(NUM_PIPES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fifo_req_i,
    input  logic [PIPE_W-1:0]    fifo_pipe_i,
    input  logic [NUM_PIPES-1:0] active_i,
    output logic [NUM_PIPES-1:0] acc_o,
    output logic [NUM_PIPES-1:0] rej_o,
    output logic                 ack_o
);
    logic [NUM_PIPES-1:0] sel;

    // Per-pipe selection and accept/reject split.
    always_comb begin
        for (int p = 0; p < NUM_PIPES; p++) begin
            sel[p]   = fifo_req_i && (fifo_pipe_i == PIPE_W'(p));
            acc_o[p] = sel[p] && active_i[p];
            rej_o[p] = sel[p] && !active_i[p];
        end
    end

    assign ack_o = |acc_o;

    // R9
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_o | rej_o));
    // R4
    ack_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (active_i[fifo_pipe_i] && fifo_req_i));
endmodule

// File: rtl/hpipe_slot.sv
// Module: hpipe_slot
// Holds the lifecycle state of one pipe: enable and reset bits, toggle,
// byte counter, state machine, error flag and configuration.
// Assumes: acc_i/rej_i come from a gate that saw active_o of this cycle.
module hpipe_slot
    import hpipe_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             wr_enable_i,
    input  logic             wr_reset_i,
    input  logic             wr_tgl_clr_i,
    input  logic             wr_cfg_we_i,
    input  logic [CFG_W-1:0] wr_cfg_i,
    input  logic             bus_rst_i,
    input  logic             xfer_i,
    input  logic             acc_i,
    input  logic             rej_i,
    output logic             en_o,
    output logic             rst_o,
    output logic             active_o,
    output logic             tgl_o,
    output logic             busy_o,
    output logic             err_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CFG_W-1:0] cfg_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             en_q, rst_q, tgl_q, err_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CFG_W-1:0] cfg_q;
    pipe_state_e      st_q;

    logic en_nx, rst_nx, hold_nx, xf;

    // Next values of the control bits and the hold condition.
    always_comb begin
        en_nx   = bus_rst_i ? 1'b0 : (hit_i ? wr_enable_i : en_q);
        rst_nx  = hit_i ? wr_reset_i : rst_q;
        hold_nx = !en_nx || rst_nx;
        xf      = xfer_i && en_q && !rst_q;
    end

    // Enable and reset bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            en_q  <= en_nx;
            rst_q <= rst_nx;
        end
    end

    // Configuration word: kept across pipe reset, allocated bit dropped on bus reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            if (hit_i && wr_cfg_we_i) cfg_q <= wr_cfg_i;
            if (bus_rst_i) cfg_q[0] <= 1'b0;
        end
    end

    // Data toggle: cleared when disabled or by strobe, flipped on a transaction.
    always_ff @(posedge clk) begin
        if (!rst_n)                     tgl_q <= 1'b0;
        else if (!en_nx)                tgl_q <= 1'b0;
        else if (hit_i && wr_tgl_clr_i) tgl_q <= 1'b0;
        else if (xf && !hold_nx)        tgl_q <= !tgl_q;
    end

    // Bank byte counter and pipe state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            st_q  <= PS_HOLD;
        end else if (hold_nx) begin
            cnt_q <= '0;
            st_q  <= PS_HOLD;
        end else if (xf) begin
            cnt_q <= acc_i ? CNT_W'(1) : '0;
            st_q  <= acc_i ? PS_FILL : PS_READY;
        end else if (acc_i) begin
            cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
            st_q  <= PS_FILL;
        end else if (st_q == PS_HOLD) begin
            st_q  <= PS_READY;
        end
    end

    // Sticky access-error flag, cleared by a reset-setting write.
    always_ff @(posedge clk) begin
        if (!rst_n)                   err_q <= 1'b0;
        else if (hit_i && wr_reset_i) err_q <= 1'b0;
        else if (rej_i)               err_q <= 1'b1;
    end

    assign en_o     = en_q;
    assign rst_o    = rst_q;
    assign active_o = en_q && !rst_q;
    assign tgl_o    = tgl_q;
    assign busy_o   = (st_q == PS_FILL);
    assign err_o    = err_q;
    assign cnt_o    = cnt_q;
    assign cfg_o    = cfg_q;

    // R3
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && wr_reset_i) |=> (cnt_q == '0 && st_q == PS_HOLD && !err_q));
    // R4
    reject_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rej_i && !(hit_i && wr_reset_i)) |=> ($stable(cnt_q) && err_q));
    // R6
    tgl_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && wr_tgl_clr_i) |=> !tgl_q);
    // R7
    off_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!tgl_q && cnt_q == '0 && st_q != PS_FILL));
    // R5
    xfer_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && en_q && !rst_q && !hit_i && !bus_rst_i) |=> (tgl_q != $past(tgl_q)));
    // R11
    reset_keeps_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_q && en_q && !bus_rst_i && !(hit_i && (wr_tgl_clr_i || !wr_enable_i))) |=> $stable(tgl_q));
endmodule

// File: rtl/hpipe_lifecycle.sv
// Module: hpipe_lifecycle (top)
// Reset/enable lifecycle for NUM_PIPES host pipes: the register write decode,
// the FIFO gate and one slot per pipe.
// Assumes: NUM_PIPES >= 2; addresses are below NUM_PIPES.
module hpipe_lifecycle #(
    parameter int NUM_PIPES = 4,
    parameter int CNT_W     = 8,
    parameter int CFG_W     = 16,
    localparam int PIPE_W   = $clog2(NUM_PIPES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid_i,
    input  logic [PIPE_W-1:0]          wr_pipe_i,
    input  logic                       wr_enable_i,
    input  logic                       wr_reset_i,
    input  logic                       wr_tgl_clr_i,
    input  logic                       wr_cfg_we_i,
    input  logic [CFG_W-1:0]           wr_cfg_i,
    input  logic                       bus_rst_done_i,
    input  logic [NUM_PIPES-1:0]       xfer_done_i,
    input  logic                       fifo_req_i,
    input  logic [PIPE_W-1:0]          fifo_pipe_i,
    output logic                       fifo_ack_o,
    output logic [NUM_PIPES-1:0]       pipe_en_o,
    output logic [NUM_PIPES-1:0]       pipe_rst_o,
    output logic [NUM_PIPES-1:0]       pipe_tgl_o,
    output logic [NUM_PIPES-1:0]       pipe_busy_o,
    output logic [NUM_PIPES-1:0]       pipe_err_o,
    output logic [NUM_PIPES*CNT_W-1:0] pipe_cnt_o,
    output logic [NUM_PIPES*CFG_W-1:0] pipe_cfg_o
);
    logic [NUM_PIPES-1:0] active, acc, rej;

    hpipe_fifo_gate #(.NUM_PIPES(NUM_PIPES)) gate_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_req_i (fifo_req_i),
        .fifo_pipe_i(fifo_pipe_i),
        .active_i   (active),
        .acc_o      (acc),
        .rej_o      (rej),
        .ack_o      (fifo_ack_o)
    );

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_slot
        logic hit;
        assign hit = wr_valid_i && (wr_pipe_i == PIPE_W'(p));

        hpipe_slot #(.CNT_W(CNT_W), .CFG_W(CFG_W)) slot_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .hit_i       (hit),
            .wr_enable_i (wr_enable_i),
            .wr_reset_i  (wr_reset_i),
            .wr_tgl_clr_i(wr_tgl_clr_i),
            .wr_cfg_we_i (wr_cfg_we_i),
            .wr_cfg_i    (wr_cfg_i),
            .bus_rst_i   (bus_rst_done_i),
            .xfer_i      (xfer_done_i[p]),
            .acc_i       (acc[p]),
            .rej_i       (rej[p]),
            .en_o        (pipe_en_o[p]),
            .rst_o       (pipe_rst_o[p]),
            .active_o    (active[p]),
            .tgl_o       (pipe_tgl_o[p]),
            .busy_o      (pipe_busy_o[p]),
            .err_o       (pipe_err_o[p]),
            .cnt_o       (pipe_cnt_o[p*CNT_W +: CNT_W]),
            .cfg_o       (pipe_cfg_o[p*CFG_W +: CFG_W])
        );
    end

    // R8
    bus_rst_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_done_i |=> (pipe_en_o == '0));
endmodule

// File: tb/hpipe_lifecycle_tb_top.sv
module hpipe_lifecycle_tb_top;
    localparam int N = 4;
    localparam int CW = 8;
    localparam int FW = 16;
    localparam int PW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 0, wr_enable = 0, wr_reset = 0, wr_tgl_clr = 0, wr_cfg_we = 0;
    logic [PW-1:0] wr_pipe = '0, fifo_pipe = '0;
    logic [FW-1:0] wr_cfg = '0;
    logic bus_rst = 0, fifo_req = 0;
    logic [N-1:0] xfer = '0;
    logic fifo_ack;
    logic [N-1:0] en_o, rst_o, tgl_o, busy_o, err_o;
    logic [N*CW-1:0] cnt_o;
    logic [N*FW-1:0] cfg_o;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    // Model state
    bit m_en[N], m_rst[N], m_tgl[N], m_busy[N], m_err[N];
    int m_cnt[N];
    logic [FW-1:0] m_cfg[N];

    always #4 clk = ~clk;

    hpipe_lifecycle #(.NUM_PIPES(N), .CNT_W(CW), .CFG_W(FW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid), .wr_pipe_i(wr_pipe),
        .wr_enable_i(wr_enable), .wr_reset_i(wr_reset), .wr_tgl_clr_i(wr_tgl_clr),
        .wr_cfg_we_i(wr_cfg_we), .wr_cfg_i(wr_cfg), .bus_rst_done_i(bus_rst),
        .xfer_done_i(xfer), .fifo_req_i(fifo_req), .fifo_pipe_i(fifo_pipe),
        .fifo_ack_o(fifo_ack), .pipe_en_o(en_o), .pipe_rst_o(rst_o),
        .pipe_tgl_o(tgl_o), .pipe_busy_o(busy_o), .pipe_err_o(err_o),
        .pipe_cnt_o(cnt_o), .pipe_cfg_o(cfg_o)
    );

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_ack();
        return fifo_req && m_en[fifo_pipe] && !m_rst[fifo_pipe];
    endfunction

    task automatic model_step();
        for (int p = 0; p < N; p++) begin
            bit hit, en_n, rs_n, act, acc, rej, xf, hold;
            hit  = wr_valid && (wr_pipe == PW'(p));
            en_n = bus_rst ? 1'b0 : (hit ? wr_enable : m_en[p]);
            rs_n = hit ? wr_reset : m_rst[p];
            act  = m_en[p] && !m_rst[p];
            acc  = fifo_req && (fifo_pipe == PW'(p)) && act;
            rej  = fifo_req && (fifo_pipe == PW'(p)) && !act;
            xf   = xfer[p] && act;
            hold = !en_n || rs_n;
            if (!en_n) m_tgl[p] = 0;
            else if (hit && wr_tgl_clr) m_tgl[p] = 0;
            else if (xf && !hold) m_tgl[p] = !m_tgl[p];
            if (hold) begin m_cnt[p] = 0; m_busy[p] = 0; end
            else if (xf) begin m_cnt[p] = acc ? 1 : 0; m_busy[p] = acc; end
            else if (acc) begin
                if (m_cnt[p] < (1 << CW) - 1) m_cnt[p]++;
                m_busy[p] = 1;
            end
            if (hit && wr_reset) m_err[p] = 0;
            else if (rej) m_err[p] = 1;
            if (hit && wr_cfg_we) m_cfg[p] = wr_cfg;
            if (bus_rst) m_cfg[p][0] = 1'b0;
            m_en[p] = en_n;
            m_rst[p] = rs_n;
        end
    endtask

    task automatic compare_all();
        for (int p = 0; p < N; p++) begin
            chk("R2 enable", en_o[p], m_en[p]);
            chk("R2 reset bit", rst_o[p], m_rst[p]);
            chk("R5 toggle", tgl_o[p], m_tgl[p]);
            chk("R9 busy", busy_o[p], m_busy[p]);
            chk("R9 count", cnt_o[p*CW +: CW], m_cnt[p]);
            chk("R4 error flag", err_o[p], m_err[p]);
            chk("R10 config", cfg_o[p*FW +: FW], m_cfg[p]);
        end
    endtask

    // One cycle: inputs already driven after a negedge.
    task automatic step();
        #1;
        chk("R9 fifo ack", fifo_ack, exp_ack());
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        wr_valid = 0; wr_enable = 0; wr_reset = 0; wr_tgl_clr = 0; wr_cfg_we = 0;
        wr_cfg = '0; bus_rst = 0; xfer = '0; fifo_req = 0;
    endtask

    task automatic do_write(int p, bit en, bit rs, bit tc, bit cw, logic [FW-1:0] c);
        idle();
        wr_valid = 1; wr_pipe = PW'(p); wr_enable = en; wr_reset = rs;
        wr_tgl_clr = tc; wr_cfg_we = cw; wr_cfg = c;
        step();
        idle();
    endtask

    task automatic do_fifo(int p);
        idle(); fifo_req = 1; fifo_pipe = PW'(p); step(); idle();
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int p = 0; p < N; p++) begin
            m_en[p] = 0; m_rst[p] = 0; m_tgl[p] = 0; m_busy[p] = 0;
            m_err[p] = 0; m_cnt[p] = 0; m_cfg[p] = '0;
        end
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 enables", en_o, 0);
        chk("R1 toggles", tgl_o, 0);
        chk("R1 counts", cnt_o, 0);
        chk("R1 configs", cfg_o, 0);
        chk("R1 errors", err_o | busy_o | rst_o, 0);

        // R2/R10 enable pipe 0 and configure it
        do_write(0, 1, 0, 0, 1, 16'hABCD);
        chk("R2 pipe0 enabled", en_o[0], 1);
        chk("R10 pipe0 config", cfg_o[FW-1:0], 16'hABCD);
        repeat (3) do_fifo(0);
        chk("R9 count after 3", cnt_o[CW-1:0], 3);
        chk("R9 busy", busy_o[0], 1);
        // R5 transaction complete
        idle(); xfer[0] = 1; step(); idle();
        chk("R5 toggle flipped", tgl_o[0], 1);
        chk("R5 bank released", cnt_o[CW-1:0], 0);
        do_fifo(0); do_fifo(0);
        // R3 pipe reset keeps toggle, enable, config
        do_write(0, 1, 1, 0, 0, '0);
        chk("R3 count cleared", cnt_o[CW-1:0], 0);
        chk("R3 busy cleared", busy_o[0], 0);
        chk("R3 enable kept", en_o[0], 1);
        chk("R3 config kept", cfg_o[FW-1:0], 16'hABCD);
        chk("R11 toggle kept in reset", tgl_o[0], 1);
        // R4 access while in reset
        idle(); fifo_req = 1; fifo_pipe = 0; #1;
        chk("R4 no ack in reset", fifo_ack, 0);
        step(); idle();
        chk("R4 error raised", err_o[0], 1);
        chk("R4 count unchanged", cnt_o[CW-1:0], 0);
        // R10 config write during reset
        do_write(0, 1, 1, 0, 1, 16'h1235);
        chk("R10 config in reset", cfg_o[FW-1:0], 16'h1235);
        chk("R3 error cleared", err_o[0], 0);
        do_write(0, 1, 0, 0, 0, '0);
        chk("R11 toggle kept after reset", tgl_o[0], 1);
        // R6 toggle clear vs transaction in same cycle
        idle(); wr_valid = 1; wr_pipe = 0; wr_enable = 1; wr_tgl_clr = 1; xfer[0] = 1;
        step(); idle();
        chk("R6 clear wins", tgl_o[0], 0);
        // R9 saturation
        repeat (260) do_fifo(0);
        chk("R9 saturated", cnt_o[CW-1:0], 255);
        idle(); xfer[0] = 1; step(); idle();
        // R7 disable clears toggle and count
        do_fifo(0);
        do_write(0, 0, 0, 0, 0, '0);
        chk("R7 toggle cleared", tgl_o[0], 0);
        chk("R7 count cleared", cnt_o[CW-1:0], 0);
        do_fifo(0);
        chk("R4 error on disabled", err_o[0], 1);
        // R8 bus reset
        do_write(1, 1, 0, 0, 1, 16'h00FF);
        do_write(0, 1, 0, 0, 0, '0);
        idle(); bus_rst = 1; wr_valid = 1; wr_pipe = 2; wr_enable = 1; step(); idle();
        chk("R8 all disabled", en_o, 0);
        chk("R8 pipe1 deallocated", cfg_o[2*FW-1:FW], 16'h00FE);
        chk("R8 pipe0 deallocated", cfg_o[FW-1:0], 16'h1234);

        // Constrained random phase
        for (int p = 0; p < N; p++) do_write(p, 1, 0, 0, 1, FW'($urandom) | 1);
        for (int i = 0; i < 4000; i++) begin
            idle();
            if ($urandom_range(5) == 0) begin
                wr_valid = 1; wr_pipe = PW'($urandom_range(N-1));
                wr_enable = ($urandom_range(7) != 0);
                wr_reset = ($urandom_range(7) == 0);
                wr_tgl_clr = ($urandom_range(3) == 0);
                wr_cfg_we = ($urandom_range(2) == 0);
                wr_cfg = FW'($urandom);
            end
            bus_rst = ($urandom_range(199) == 0);
            fifo_req = $urandom_range(1);
            fifo_pipe = PW'($urandom_range(N-1));
            for (int p = 0; p < N; p++) xfer[p] = ($urandom_range(7) == 0);
            step();
        end
        idle();
        finish_run();
    end
endmodule